// File: doc/BRIEF.md
# One-Time-Programmable Word Programming Sequencer

This block burns one 72-bit physical word of a one-time-programmable cell array. The word is built from 64 data bits, taken from two 32-bit inputs, and 8 check bits that the block derives from the data. A single-cycle start request launches an attempt at a 13-bit word address. The sequencer steps through the bit positions of the word in ascending order. For every position selected for this attempt it holds a programming strobe for a configurable number of clock cycles. It then reads the whole word back and compares it with the target.

The result is reported on three flags. The zero flag means an all-zero word was skipped. The correctable flag means exactly one target bit did not take. The uncorrectable flag means two or more target bits did not take. The failing positions are kept in a 72-bit mask. A retry request, accepted only after a completed attempt, pulses only those positions. A ready output is high whenever the sequencer is idle.

Top module: `otp_word_prog_seq`

## Requirements
- R1: After reset, ready is 1, the zero, correctable and uncorrectable flags are 0, and no programming strobe is active.
- R2: A start with retry low and nonzero data is accepted only while ready is 1. Ready is 0 from the edge that samples the start until the attempt ends.
- R3: The target word is laid out as bits 31:0 = data_lo, bits 63:32 = data_hi and bits 71:64 = check bits. Check bit k is the XOR of every data bit j with j mod 8 = k. A first attempt pulses each target bit that is 1, each exactly once, in ascending bit order.
- R4: Every pulse keeps cell_pgm high and cell_bit constant for exactly pulse_len+1 cycles. cell_addr equals the address sampled at start for the whole attempt.
- R5: A start with retry low and all 64 data bits 0 produces no pulse and leaves ready at 1. One cycle later the zero flag is 1 and both error flags are 0.
- R6: At the end of an attempt the sequencer counts the failing bits (target 1, read back 0). Zero failures clear both error flags. Exactly one failure sets only the correctable flag. Two or more set only the uncorrectable flag.
- R7: A retry pulses exactly the bits that failed in the previous attempt. The target is still taken from data_hi and data_lo.
- R8: A retry request is ignored after reset and after a zero-word start. It causes no pulse, keeps ready at 1 and leaves all flags unchanged.
- R9: A start that arrives while ready is 0 is ignored. The running attempt keeps its address and its set of pulsed bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle launch request |
| retry | input | 1 | With start: re-pulse only the previously failed bits |
| addr | input | 13 | Physical word address |
| data_lo | input | 32 | Data bits 31:0 |
| data_hi | input | 32 | Data bits 63:32 |
| pulse_len | input | 8 | Pulse length in cycles minus one |
| cell_rdata | input | 72 | Read-back word from the cell array |
| cell_pgm | output | 1 | Programming strobe |
| cell_rd | output | 1 | Read-back strobe (verify cycle) |
| cell_addr | output | 13 | Word address to the cell array |
| cell_bit | output | 7 | Bit position being pulsed |
| ready | output | 1 | 1 when idle |
| zero_flag | output | 1 | Last start held an all-zero word |
| err_cor | output | 1 | Exactly one bit failed |
| err_unc | output | 1 | Two or more bits failed |

## Verification
The embedded assertions check the following on every cycle:
- a strobe only ever hits a bit selected for the current attempt;
- a pulse holds its bit position until its length expires;
- the two error flags are never set together;
- the address stays put while the sequencer is busy;
- zero-word starts and unarmed retries never leave the idle state.

The ascending order of pulses, the exact pulse length, the failure classification and the retry mask can only be shown by the bench scenarios. These run many data patterns, pulse lengths and numbers of stuck cells against a behavioural cell model, with the expected word, check bits and failure counts worked out arithmetically.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;
    localparam int HALF_W  = 32;
    localparam int DATA_W  = 2 * HALF_W;
    localparam int CHK_W   = 8;
    localparam int WORD_W  = DATA_W + CHK_W;
    localparam int IDX_W   = $clog2(WORD_W);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_PULSE,
        ST_VERIFY
    } seq_state_e;

    // check bit k folds every data bit whose index is congruent to k mod CHK_W
    function automatic logic [CHK_W-1:0] check_bits(input logic [DATA_W-1:0] d);
        logic [CHK_W-1:0] c;
        c = '0;
        for (int j = 0; j < DATA_W; j++) begin
            c[j % CHK_W] = c[j % CHK_W] ^ d[j];
        end
        return c;
    endfunction
endpackage

// File: rtl/otp_pulse_timer.sv
module otp_pulse_timer #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [LEN_W-1:0] len,
    output logic             done
);
    logic [LEN_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = len;
        end else if (run && cnt_q != '0) begin
            cnt_d = cnt_q - LEN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = run && (cnt_q == '0);
endmodule

// File: rtl/otp_fail_classify.sv
module otp_fail_classify #(
    parameter int N = 72
) (
    input  logic [N-1:0] fail,
    output logic         one,
    output logic         many
);
    localparam int CNT_W = $clog2(N + 1);
    logic [CNT_W-1:0] cnt;

    always_comb begin
        cnt = '0;
        for (int i = 0; i < N; i++) begin
            cnt = cnt + CNT_W'(fail[i]);
        end
    end

    assign one  = (cnt == CNT_W'(1));
    assign many = (cnt > CNT_W'(1));
endmodule

// File: rtl/otp_word_prog_seq.sv
module otp_word_prog_seq
    import otp_prog_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int PW_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              retry,
    input  logic [ADDR_W-1:0] addr,
    input  logic [HALF_W-1:0] data_lo,
    input  logic [HALF_W-1:0] data_hi,
    input  logic [PW_W-1:0]   pulse_len,
    input  logic [WORD_W-1:0] cell_rdata,
    output logic              cell_pgm,
    output logic              cell_rd,
    output logic [ADDR_W-1:0] cell_addr,
    output logic [IDX_W-1:0]  cell_bit,
    output logic              ready,
    output logic              zero_flag,
    output logic              err_cor,
    output logic              err_unc
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] target;
        logic [WORD_W-1:0] mask;
        logic [WORD_W-1:0] fail;
        logic [ADDR_W-1:0] addr;
        logic              armed;
        logic              zero;
        logic              cor;
        logic              unc;
    } seq_regs_t;

    seq_regs_t cur_q, nxt_d;

    logic              timer_load;
    logic              pulse_done;
    logic              cls_one, cls_many;
    logic [WORD_W-1:0] fail_now;
    logic [WORD_W-1:0] new_target;
    logic [DATA_W-1:0] data_in;

    assign data_in    = {data_hi, data_lo};
    assign new_target = {check_bits(data_in), data_in};
    assign fail_now   = cur_q.target & ~cell_rdata;

    otp_pulse_timer #(.LEN_W(PW_W)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (timer_load),
        .run   (cur_q.st == ST_PULSE),
        .len   (pulse_len),
        .done  (pulse_done)
    );

    otp_fail_classify #(.N(WORD_W)) classify_i (
        .fail (fail_now),
        .one  (cls_one),
        .many (cls_many)
    );

    always_comb begin
        nxt_d      = cur_q;
        timer_load = 1'b0;
        unique case (cur_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (retry) begin
                        if (cur_q.armed) begin
                            nxt_d.target = new_target;
                            nxt_d.mask   = cur_q.fail;
                            nxt_d.st     = ST_SCAN;
                            nxt_d.idx    = '0;
                            nxt_d.addr   = addr;
                            nxt_d.zero   = 1'b0;
                            nxt_d.cor    = 1'b0;
                            nxt_d.unc    = 1'b0;
                        end
                    end else if (data_in == '0) begin
                        nxt_d.zero  = 1'b1;
                        nxt_d.cor   = 1'b0;
                        nxt_d.unc   = 1'b0;
                        nxt_d.armed = 1'b0;
                    end else begin
                        nxt_d.target = new_target;
                        nxt_d.mask   = new_target;
                        nxt_d.st     = ST_SCAN;
                        nxt_d.idx    = '0;
                        nxt_d.addr   = addr;
                        nxt_d.zero   = 1'b0;
                        nxt_d.cor    = 1'b0;
                        nxt_d.unc    = 1'b0;
                    end
                end
            end
            ST_SCAN: begin
                if (cur_q.mask[cur_q.idx]) begin
                    nxt_d.st   = ST_PULSE;
                    timer_load = 1'b1;
                end else if (cur_q.idx == LAST_IDX) begin
                    nxt_d.st = ST_VERIFY;
                end else begin
                    nxt_d.idx = cur_q.idx + IDX_W'(1);
                end
            end
            ST_PULSE: begin
                if (pulse_done) begin
                    if (cur_q.idx == LAST_IDX) begin
                        nxt_d.st = ST_VERIFY;
                    end else begin
                        nxt_d.idx = cur_q.idx + IDX_W'(1);
                        nxt_d.st  = ST_SCAN;
                    end
                end
            end
            ST_VERIFY: begin
                nxt_d.fail  = fail_now;
                nxt_d.cor   = cls_one;
                nxt_d.unc   = cls_many;
                nxt_d.armed = 1'b1;
                nxt_d.st    = ST_IDLE;
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_IDLE, idx: '0, target: '0, mask: '0, fail: '0,
                       addr: '0, armed: 1'b0, zero: 1'b0, cor: 1'b0, unc: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign cell_pgm  = (cur_q.st == ST_PULSE);
    assign cell_rd   = (cur_q.st == ST_VERIFY);
    assign cell_addr = cur_q.addr;
    assign cell_bit  = cur_q.idx;
    assign ready     = (cur_q.st == ST_IDLE);
    assign zero_flag = cur_q.zero;
    assign err_cor   = cur_q.cor;
    assign err_unc   = cur_q.unc;

    AST_PULSE_ONLY_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        cell_pgm |-> cur_q.mask[cell_bit]); // R7

    AST_PULSE_BIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_pgm && !pulse_done) |=> (cell_pgm && $stable(cell_bit))); // R4

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_cor && err_unc)); // R6

    AST_ZERO_NO_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && start && !retry && data_in == '0) |=> (ready && zero_flag)); // R5

    AST_UNARMED_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && start && retry && !cur_q.armed) |=>
            (ready && $stable(zero_flag) && $stable(err_cor) && $stable(err_unc))); // R8

    AST_BUSY_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && $past(!ready)) |-> $stable(cell_addr)); // R9
endmodule

// File: tb/otp_word_prog_seq_tb.sv
module otp_word_prog_seq_tb_top;
    localparam int AW = 13;
    localparam int WW = 72;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          retry = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   data_lo = '0;
    logic [31:0]   data_hi = '0;
    logic [7:0]    pulse_len = '0;
    logic [WW-1:0] cell_rdata;
    logic          cell_pgm, cell_rd, ready, zero_flag, err_cor, err_unc;
    logic [AW-1:0] cell_addr;
    logic [6:0]    cell_bit;

    always #10 clk = ~clk;

    otp_word_prog_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .retry(retry), .addr(addr),
        .data_lo(data_lo), .data_hi(data_hi), .pulse_len(pulse_len),
        .cell_rdata(cell_rdata), .cell_pgm(cell_pgm), .cell_rd(cell_rd),
        .cell_addr(cell_addr), .cell_bit(cell_bit), .ready(ready),
        .zero_flag(zero_flag), .err_cor(err_cor), .err_unc(err_unc)
    );

    // behavioural cell array with stuck-at-0 injection
    logic [WW-1:0] mem   [16];
    logic [WW-1:0] stuck [16];
    assign cell_rdata = mem[cell_addr[3:0]];

    int            vectors = 0;
    int            miscompares = 0;
    logic [WW-1:0] pulsed;
    int            npulse, bad_len, order_err, addr_err, run_len, last_bit;
    logic          prev_pgm = 1'b0;
    logic [AW-1:0] exp_addr;

    initial begin
        for (int i = 0; i < 16; i++) begin
            mem[i] = '0;
            stuck[i] = '0;
        end
    end

    always @(negedge clk) begin
        if (cell_pgm) begin
            if (!stuck[cell_addr[3:0]][cell_bit]) mem[cell_addr[3:0]][cell_bit] = 1'b1;
            if (cell_addr != exp_addr) addr_err++;
            if (!prev_pgm) begin
                pulsed[cell_bit] = 1'b1;
                npulse++;
                if (int'(cell_bit) <= last_bit) order_err++;
                last_bit = int'(cell_bit);
                run_len = 1;
            end else begin
                run_len++;
            end
        end else if (prev_pgm) begin
            if (run_len != int'(pulse_len) + 1) bad_len++;
        end
        prev_pgm = cell_pgm;
    end

    task automatic chk(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] make_target(input logic [31:0] hi, input logic [31:0] lo);
        logic [7:0] c;
        logic [63:0] d;
        d = {hi, lo};
        for (int k = 0; k < 8; k++) begin
            c[k] = 1'b0;
            for (int m = 0; m < 8; m++) c[k] = c[k] ^ d[8 * m + k];
        end
        return {c, d};
    endfunction

    function automatic int ones(input logic [WW-1:0] v);
        int n = 0;
        for (int i = 0; i < WW; i++) n += int'(v[i]);
        return n;
    endfunction

    // launch one request and wait for idle; returns ready seen one cycle after launch
    task automatic run_req(input logic [AW-1:0] a, input logic [31:0] hi, input logic [31:0] lo,
                           input logic rt, output logic rdy_after);
        int guard;
        pulsed = '0; npulse = 0; bad_len = 0; order_err = 0; addr_err = 0; last_bit = -1;
        exp_addr = a;
        @(negedge clk);
        addr = a; data_hi = hi; data_lo = lo; retry = rt; start = 1'b1;
        @(negedge clk);
        start = 1'b0; retry = 1'b0;
        rdy_after = ready;
        guard = 0;
        while (!ready && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        if (guard >= 5000) begin
            miscompares++;
            $display("FAIL R2 watchdog actual=busy expected=idle");
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        miscompares++;
        $display("FAIL R2 global watchdog actual=hung expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    logic [31:0]   pat_hi [6];
    logic [31:0]   pat_lo [6];
    logic [7:0]    pw_set [3];

    initial begin
        logic          rdy;
        logic [WW-1:0] tgt, exp_fail, sel;
        int            cnt;
        pat_hi[0] = 32'h0000_0000; pat_lo[0] = 32'h0000_0001;
        pat_hi[1] = 32'h8000_0000; pat_lo[1] = 32'h0000_0003;
        pat_hi[2] = 32'hFFFF_FFFF; pat_lo[2] = 32'hFFFF_FFFF;
        pat_hi[3] = 32'hA5A5_0F0F; pat_lo[3] = 32'h1234_5678;
        pat_hi[4] = 32'h0101_0101; pat_lo[4] = 32'h0000_0000;
        pat_hi[5] = 32'h0000_00FF; pat_lo[5] = 32'hC000_0000;
        pw_set[0] = 8'd0; pw_set[1] = 8'd1; pw_set[2] = 8'd4;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready", {71'd0, ready}, 72'd1);
        chk("R1 flags", {69'd0, zero_flag, err_cor, err_unc}, 72'd0);
        chk("R1 strobe", {71'd0, cell_pgm}, 72'd0);

        // R8: retry right after reset
        run_req(13'd2, 32'h1, 32'h1, 1'b1, rdy);
        chk("R8 ready stays", {71'd0, rdy}, 72'd1);
        chk("R8 no pulse", pulsed, 72'd0);
        chk("R8 flags kept", {69'd0, zero_flag, err_cor, err_unc}, 72'd0);

        // R5: all-zero word
        run_req(13'd3, 32'h0, 32'h0, 1'b0, rdy);
        chk("R5 ready stays", {71'd0, rdy}, 72'd1);
        chk("R5 no pulse", pulsed, 72'd0);
        chk("R5 flags", {69'd0, zero_flag, err_cor, err_unc}, 72'h4);

        // R8: retry after a zero word
        run_req(13'd3, 32'h5, 32'h5, 1'b1, rdy);
        chk("R8 ready after zero", {71'd0, rdy}, 72'd1);
        chk("R8 no pulse after zero", pulsed, 72'd0);
        chk("R8 flags after zero", {69'd0, zero_flag, err_cor, err_unc}, 72'h4);

        // sweep: patterns x pulse lengths x stuck counts
        for (int p = 0; p < 6; p++) begin
            for (int ns = 0; ns < 4; ns++) begin
                logic [3:0] a;
                a = 4'(p * 4 + ns);
                pulse_len = pw_set[(p + ns) % 3];
                tgt = make_target(pat_hi[p], pat_lo[p]);
                sel = '0; cnt = 0;
                for (int i = WW - 1; i >= 0; i--) begin
                    if (tgt[i] && cnt < ns) begin
                        sel[i] = 1'b1;
                        cnt++;
                    end
                end
                mem[a] = '0;
                stuck[a] = sel;
                run_req({9'd0, a}, pat_hi[p], pat_lo[p], 1'b0, rdy);
                exp_fail = tgt & sel;
                chk("R2 busy after launch", {71'd0, rdy}, 72'd0);
                chk("R3 pulsed set", pulsed, tgt);
                chk("R3 ascending once", 72'(order_err), 72'd0);
                chk("R4 pulse length", 72'(bad_len), 72'd0);
                chk("R4 address", 72'(addr_err), 72'd0);
                chk("R6 flags", {69'd0, zero_flag, err_cor, err_unc},
                    {69'd0, 1'b0, ones(exp_fail) == 1, ones(exp_fail) > 1});
                // retry with cells still stuck: same mask again
                run_req({9'd0, a}, pat_hi[p], pat_lo[p], 1'b1, rdy);
                chk("R7 retry pulses failed bits", pulsed, exp_fail);
                chk("R6 retry flags stuck", {69'd0, zero_flag, err_cor, err_unc},
                    {69'd0, 1'b0, ones(exp_fail) == 1, ones(exp_fail) > 1});
                // release stuck cells, retry heals the word
                stuck[a] = '0;
                run_req({9'd0, a}, pat_hi[p], pat_lo[p], 1'b1, rdy);
                chk("R7 retry healed pulses", pulsed, exp_fail);
                chk("R7 word after retry", mem[a], tgt);
                chk("R6 clean flags", {69'd0, zero_flag, err_cor, err_unc}, 72'd0);
            end
        end

        // R9: start while busy is ignored
        pulse_len = 8'd2;
        mem[15] = '0;
        stuck[15] = '0;
        tgt = make_target(32'h0000_0010, 32'h0000_0100);
        pulsed = '0; npulse = 0; bad_len = 0; order_err = 0; addr_err = 0; last_bit = -1;
        exp_addr = 13'd15;
        @(negedge clk);
        addr = 13'd15; data_hi = 32'h0000_0010; data_lo = 32'h0000_0100; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        addr = 13'd9; data_hi = 32'hFFFF_0000; data_lo = 32'h0000_FFFF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int g = 0; g < 5000 && !ready; g++) @(negedge clk);
        chk("R9 pulsed set kept", pulsed, tgt);
        chk("R9 address kept", 72'(addr_err), 72'd0);
        chk("R9 word", mem[15], tgt);
        @(negedge clk);
        chk("R9 idle after", {71'd0, ready}, 72'd1);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule